// File: doc/BRIEF.md
# Dual Numerically Controlled Clock Synthesizer with Phase Offset

This block builds two independent clock outputs from one fast master clock, each by phase accumulation. Each channel takes an integer count of 2 kHz steps and scales it by a step constant fixed at elaboration into a 48-bit accumulator increment. The output clock is the most significant bit of the accumulator's top byte after an 8-bit phase offset has been added to that byte. The offset moves the output edges in steps of 1/256 of an output period.

A change to either setting does not restart the accumulator. The new multiple and the new offset are taken in only on the cycle in which the accumulator wraps, so a running output never sees a partial period built from two different settings. A multiple of zero, or one above 38880 (77.76 MHz), marks the setting as invalid. An invalid multiple drives the channel's output low and raises its error flag. Each channel also gives a one-cycle strobe on every rising edge of its output, for logic that runs in the master clock domain.

Top module: `dfs_pair`

## Requirements
- R1: While reset is high, every channel's synth_clk, edge_stb and err are 0 and its accumulator is cleared.
- R2: While a channel runs, its 48-bit accumulator gains mult × floor(2000 × 2^48 / FCLK_HZ) on every clock, with the increment and the sum both taken modulo 2^48.
- R3: synth_clk is bit 7 of (accumulator bits 47:40 + phase) mod 256. It is registered, so it shows the accumulator value written at the same clock edge. Raising phase by 128 inverts the output.
- R4: When mult is 0 or greater than 38880, err reads 1 and synth_clk and edge_stb read 0 from the next clock onward, and the accumulator is cleared. err reads 0 one clock after mult becomes valid again; 38880 is valid.
- R5: While a channel runs, the active increment and offset change only on a clock in which the 48-bit add carries out. On that clock both are loaded from the inputs, and that clock's output already uses the new offset.
- R6: When en is low, the channel's accumulator is cleared and synth_clk and edge_stb read 0 from the next clock onward. The first enabled clock with a valid multiple loads both settings and restarts from an accumulator of 0.
- R7: edge_stb is high for exactly the cycles in which synth_clk has just gone from 0 to 1.
- R8: The channels share only the clock and reset. The settings of one channel never change the outputs of the other.
- R9: Over a window of N clocks, the number of rising edges on synth_clk is within one of N × mult × 2000 / FCLK_HZ.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | NCH | Per-channel enable |
| mult | input | NCH×16 | Per-channel frequency as a count of 2 kHz steps |
| phase | input | NCH×8 | Per-channel phase offset in 1/256 output period steps |
| synth_clk | output | NCH | Synthesized clock per channel |
| edge_stb | output | NCH | One-cycle pulse on each rising edge of synth_clk |
| err | output | NCH | Multiple out of range, per channel |

## Verification
Some rules are checked by assertions on every clock. These are: the strobe matches a rising output, the active settings hold steady between wraps, an invalid multiple or a low enable silences the output, and reset clears the state. The exact output waveform is shown only by the bench's cycle-accurate model. This covers the increment arithmetic, the effect of the offset, and a setting change landing at the wrap. Its scenarios include a setting change in mid-period, disabling and re-enabling a channel, the range limits, a very low multiple, and two channels that differ only by half a period. The long-term edge rate can only be measured over a window in the bench.

// File: rtl/dfs_pkg.sv
package dfs_pkg;

    localparam int ACC_W    = 48;
    localparam int TAP_W    = 8;
    localparam int MULT_W   = 16;
    localparam int MULT_MAX = 38880;
    localparam int STEP_HZ  = 2000;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } dfs_state_e;

    typedef struct packed {
        logic [ACC_W-1:0] inc;
        logic [TAP_W-1:0] ph;
    } dfs_cfg_t;

    // Accumulator increment for one 2 kHz step at the given master clock.
    function automatic logic [ACC_W-1:0] step_for(input longint unsigned fclk);
        longint unsigned num;
        num = 64'(STEP_HZ) << ACC_W;
        return ACC_W'(num / fclk);
    endfunction

    function automatic logic mult_ok(input logic [MULT_W-1:0] m);
        return (m != '0) && (32'(m) <= MULT_MAX);
    endfunction

    function automatic logic tap_bit(input logic [ACC_W-1:0] acc,
                                     input logic [TAP_W-1:0] ph);
        logic [TAP_W-1:0] t;
        t = acc[ACC_W-1 -: TAP_W] + ph;
        return t[TAP_W-1];
    endfunction

endpackage

// File: rtl/dfs_incr.sv
module dfs_incr
    import dfs_pkg::*;
#(
    parameter longint unsigned FCLK_HZ = 64'd311040000
) (
    input  logic [MULT_W-1:0] mult,
    output logic [ACC_W-1:0]  inc,
    output logic              ok
);
    localparam logic [ACC_W-1:0] STEP = step_for(FCLK_HZ);

    always_comb begin
        inc = ACC_W'(mult) * STEP;
        ok  = mult_ok(mult);
    end
endmodule

// File: rtl/dfs_out_tap.sv
module dfs_out_tap
    import dfs_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             active,
    input  logic [ACC_W-1:0] acc_nx,
    input  logic [TAP_W-1:0] ph_nx,
    output logic             synth_clk,
    output logic             edge_stb
);
    logic tap_nx;

    always_comb tap_nx = tap_bit(acc_nx, ph_nx);

    always_ff @(posedge clk) begin
        if (rst || !active) begin
            synth_clk <= 1'b0;
            edge_stb  <= 1'b0;
        end else begin
            synth_clk <= tap_nx;
            edge_stb  <= tap_nx & ~synth_clk;
        end
    end

    // R7: strobe exactly on rising output
    a_r7_strobe_on_rise: assert property (@(posedge clk) disable iff (rst)
        edge_stb == $rose(synth_clk));
endmodule

// File: rtl/dfs_channel.sv
module dfs_channel
    import dfs_pkg::*;
#(
    parameter longint unsigned FCLK_HZ = 64'd311040000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic [MULT_W-1:0] mult,
    input  logic [TAP_W-1:0]  phase,
    output logic              synth_clk,
    output logic              edge_stb,
    output logic              err
);
    logic [ACC_W-1:0] inc_in;
    logic             ok;
    logic [ACC_W-1:0] acc, acc_nx;
    logic [ACC_W:0]   sum_w;
    logic             carry;
    logic             go;
    dfs_cfg_t         cfg, cfg_nx, cfg_in;
    dfs_state_e       st, st_nx;

    dfs_incr #(.FCLK_HZ(FCLK_HZ)) u_incr (
        .mult (mult),
        .inc  (inc_in),
        .ok   (ok)
    );

    always_comb begin
        cfg_in = '{inc: inc_in, ph: phase};
        sum_w  = {1'b0, acc} + {1'b0, cfg.inc};
        carry  = sum_w[ACC_W];
        go     = en && ok;
        st_nx  = st;
        acc_nx = acc;
        cfg_nx = cfg;
        if (!go) begin
            st_nx  = ST_IDLE;
            acc_nx = '0;
        end else if (st == ST_IDLE) begin
            st_nx  = ST_RUN;
            acc_nx = '0;
            cfg_nx = cfg_in;
        end else begin
            acc_nx = sum_w[ACC_W-1:0];
            if (carry) cfg_nx = cfg_in;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= ST_IDLE;
            acc <= '0;
            cfg <= '0;
            err <= 1'b0;
        end else begin
            st  <= st_nx;
            acc <= acc_nx;
            cfg <= cfg_nx;
            err <= !ok;
        end
    end

    dfs_out_tap u_tap (
        .clk       (clk),
        .rst       (rst),
        .active    (go),
        .acc_nx    (acc_nx),
        .ph_nx     (cfg_nx.ph),
        .synth_clk (synth_clk),
        .edge_stb  (edge_stb)
    );

    // R1: reset clears state and output
    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (acc == '0 && st == ST_IDLE && !synth_clk && !err));

    // R5: settings only move on a wrap
    a_r5_cfg_held: assert property (@(posedge clk) disable iff (rst)
        (st == ST_RUN && go && !carry) |=> $stable(cfg));

    // R4: out-of-range multiple silences output and flags
    a_r4_bad_mult: assert property (@(posedge clk) disable iff (rst)
        !ok |=> (err && !synth_clk && !edge_stb && acc == '0));

    // R6: disabled channel stays quiet
    a_r6_disabled: assert property (@(posedge clk) disable iff (rst)
        !en |=> (!synth_clk && !edge_stb && acc == '0));
endmodule

// File: rtl/dfs_pair.sv
module dfs_pair
    import dfs_pkg::*;
#(
    parameter int              NCH     = 2,
    parameter longint unsigned FCLK_HZ = 64'd311040000
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [NCH-1:0]               en,
    input  logic [NCH-1:0][MULT_W-1:0]   mult,
    input  logic [NCH-1:0][TAP_W-1:0]    phase,
    output logic [NCH-1:0]               synth_clk,
    output logic [NCH-1:0]               edge_stb,
    output logic [NCH-1:0]               err
);
    // R8: each channel is a separate instance sharing only clk and rst
    for (genvar g = 0; g < NCH; g++) begin : g_ch
        dfs_channel #(.FCLK_HZ(FCLK_HZ)) u_ch (
            .clk       (clk),
            .rst       (rst),
            .en        (en[g]),
            .mult      (mult[g]),
            .phase     (phase[g]),
            .synth_clk (synth_clk[g]),
            .edge_stb  (edge_stb[g]),
            .err       (err[g])
        );
    end
endmodule

// File: tb/tb_dfs_pair.sv
module tb_dfs_pair;
    localparam longint unsigned FCLK = 64'd50000000;
    localparam longint unsigned MASK = (64'd1 << 48) - 64'd1;
    localparam longint unsigned STEP = (64'd2000 << 48) / FCLK;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [1:0]      en = '0;
    logic [1:0][15:0] mult = '0;
    logic [1:0][7:0]  phase = '0;
    logic [1:0]      synth_clk, edge_stb, err;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit cmp_on = 0;
    bit inv_on = 0;
    bit cnt_on = 0;
    int rises = 0;
    int stbs = 0;

    longint unsigned m_acc [2];
    longint unsigned m_inc [2];
    int  m_ph [2];
    bit  m_run [2];
    bit  m_clk [2];
    bit  m_stb [2];
    bit  m_err [2];

    dfs_pair #(.NCH(2), .FCLK_HZ(FCLK)) dut (
        .clk(clk), .rst(rst), .en(en), .mult(mult), .phase(phase),
        .synth_clk(synth_clk), .edge_stb(edge_stb), .err(err)
    );

    always #10 clk = ~clk;

    task automatic check(input bit good, input string req,
                         input longint act, input longint exp);
        total++;
        if (!good) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    function automatic bit tapf(longint unsigned acc, int ph);
        return bit'((((acc >> 40) + longint'(ph)) & 64'hFF) >> 7);
    endfunction

    // behavioural reference, one step per rising edge
    always @(posedge clk) begin
        for (int c = 0; c < 2; c++) begin
            bit ok, go, nclk;
            longint unsigned s;
            ok = (mult[c] != 0) && (mult[c] <= 16'd38880);
            go = en[c] && ok;
            if (rst) begin
                m_acc[c] = 0; m_inc[c] = 0; m_ph[c] = 0; m_run[c] = 0;
                m_clk[c] = 0; m_stb[c] = 0; m_err[c] = 0;
            end else begin
                m_err[c] = !ok;
                if (!go) begin
                    m_run[c] = 0; m_acc[c] = 0; m_clk[c] = 0; m_stb[c] = 0;
                end else begin
                    if (!m_run[c]) begin
                        m_run[c] = 1;
                        m_acc[c] = 0;
                        m_inc[c] = (longint'(mult[c]) * STEP) & MASK;
                        m_ph[c]  = int'(phase[c]);
                    end else begin
                        s = m_acc[c] + m_inc[c];
                        m_acc[c] = s & MASK;
                        if ((s >> 48) != 0) begin
                            m_inc[c] = (longint'(mult[c]) * STEP) & MASK;
                            m_ph[c]  = int'(phase[c]);
                        end
                    end
                    nclk = tapf(m_acc[c], m_ph[c]);
                    m_stb[c] = nclk & ~m_clk[c];
                    m_clk[c] = nclk;
                end
            end
        end
    end

    // compare away from the active edge
    always @(negedge clk) begin
        if (cmp_on) begin
            for (int c = 0; c < 2; c++) begin
                check(synth_clk[c] == m_clk[c], "R2,R3,R5 synth_clk model", synth_clk[c], m_clk[c]);
                check(edge_stb[c] == m_stb[c], "R7 edge_stb model", edge_stb[c], m_stb[c]);
                check(err[c] == m_err[c], "R4 err model", err[c], m_err[c]);
            end
        end
        if (inv_on)
            check(synth_clk[1] == !synth_clk[0], "R3 R8 half-period offset inverts",
                  synth_clk[1], !synth_clk[0]);
        if (cnt_on) begin
            if (edge_stb[0]) stbs++;
        end
    end

    logic prev0 = 1'b0;
    always @(negedge clk) begin
        if (cnt_on && synth_clk[0] && !prev0) rises++;
        prev0 <= synth_clk[0];
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000) begin
            bad++;
            total++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 190000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic wait_cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        int lo, hi;
        wait_cycles(5);
        // R1: reset state
        check(synth_clk == 2'b00, "R1 synth_clk in reset", synth_clk, 0);
        check(edge_stb == 2'b00, "R1 edge_stb in reset", edge_stb, 0);
        check(err == 2'b00, "R1 err in reset", err, 0);
        cmp_on = 1;

        // both channels same multiple, half a period apart
        mult[0] = 16'd2500; mult[1] = 16'd2500;
        phase[0] = 8'd0; phase[1] = 8'd128;
        en = 2'b11;
        rst = 1'b0;
        wait_cycles(1);
        inv_on = 1;
        wait_cycles(300);
        inv_on = 0;

        // R9 rate over a window, R7 strobe count
        cnt_on = 1;
        wait_cycles(10000);
        cnt_on = 0;
        lo = 999; hi = 1001;
        check(rises >= lo && rises <= hi, "R9 rising edges in 10000 clocks", rises, 1000);
        check(stbs == rises, "R7 strobes equal rising edges", stbs, rises);

        // R5: change settings mid-period, R8 different settings per channel
        mult[0] = 16'd5000; phase[0] = 8'd40;
        mult[1] = 16'd1000; phase[1] = 8'd3;
        wait_cycles(3000);

        // R4: out-of-range multiples on channel 1
        mult[1] = 16'd0;
        wait_cycles(1);
        check(err[1] == 1'b1, "R4 err on zero multiple", err[1], 1);
        check(synth_clk[1] == 1'b0, "R4 output low on zero multiple", synth_clk[1], 0);
        check(err[0] == 1'b0, "R8 other channel err clear", err[0], 0);
        wait_cycles(20);
        mult[1] = 16'd40000;
        wait_cycles(1);
        check(err[1] == 1'b1, "R4 err above limit", err[1], 1);
        mult[1] = 16'd38881;
        wait_cycles(5);
        check(err[1] == 1'b1 && synth_clk[1] == 1'b0, "R4 38881 rejected", err[1], 1);
        mult[1] = 16'd38880;
        wait_cycles(1);
        check(err[1] == 1'b0, "R4 38880 accepted", err[1], 0);
        wait_cycles(500);

        // R6: disable channel 0 then re-enable
        en[0] = 1'b0;
        for (int i = 0; i < 50; i++) begin
            wait_cycles(1);
            check(synth_clk[0] == 1'b0 && edge_stb[0] == 1'b0, "R6 disabled output low",
                  synth_clk[0], 0);
        end
        en[0] = 1'b1;
        mult[0] = 16'd7;
        wait_cycles(2000);

        // lowest multiple: one output period is 25000 clocks
        mult[0] = 16'd1; phase[0] = 8'd200;
        en[0] = 1'b0;
        wait_cycles(2);
        en[0] = 1'b1;
        wait_cycles(30000);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule